// File: doc/BRIEF.md
# Time-over-Threshold Hit Channel with Occupancy Loss Counting

This block sits behind one strip discriminator. It watches a comparator level, measures how long each pulse stays above threshold in units of a fixed time step, and emits one hit record per pulse with a 4-bit time-over-threshold (ToT) value. The step is `TICK_CYCLES` clock cycles, so with a 100 MHz clock and the default of one cycle, a step is 10 ns.

For self-test, the comparator can be replaced by an internal pulse source. Each generated hit carries a ToT value and opens a comparator window lasting ToT steps. While that window is open the channel is busy. A further generated hit during that time does not restart or lengthen the window. It is dropped, but it still bumps a separate busy-hit counter.

A total hit counter runs alongside the busy-hit counter. Software outside the block can divide the busy-hit count by the total count to estimate the inefficiency caused by channel occupancy. Both counters saturate instead of wrapping, and a synchronous clear input resets both of them.

Top module: `tot_hit_channel`

## Requirements
- R1: After reset, `rec_valid`, `rec_tot`, `busy`, `hits_total` and `hits_busy` are all zero.
- R2: With `selftest_en`=0, if `cmp_in` is high for L consecutive cycles, then exactly one record is produced. `rec_valid` is high for one cycle, in the cycle after `cmp_in` is first seen low. `rec_tot` in that cycle equals floor(L / `TICK_CYCLES`).
- R3: A ToT measurement that would exceed 15 (all ones in the 4-bit field) is reported as 15.
- R4: With `selftest_en`=1, a `gen_hit` accepted while idle, with `gen_tot`=T>0, raises `busy` from the next cycle. `busy` stays high for T×`TICK_CYCLES` cycles. `rec_valid` then pulses one cycle after `busy` falls, with `rec_tot`=T.
- R5: A `gen_hit` sampled while `busy` is high neither restarts nor extends the window. The record keeps the original ToT, and `hits_busy` increments by one for each such hit.
- R6: `hits_total` increments by one for every sampled `gen_hit` in self-test mode, whether it is accepted or dropped. In comparator mode it increments once per rising edge of `cmp_in`.
- R7: A self-test hit with `gen_tot`=0 is counted in `hits_total`, but it opens no window and produces no record.
- R8: Each counter stops at its maximum value (2^`CNT_W`−1) instead of wrapping.
- R9: `clr` zeroes both counters in the next cycle and takes priority over a simultaneous increment. A measurement already in progress still delivers its record.
- R10: With `selftest_en`=0, `gen_hit` has no effect: `busy` stays low and neither counter moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of both counters |
| selftest_en | input | 1 | 1: internal pulse source drives the comparator; 0: `cmp_in` does |
| cmp_in | input | 1 | Synchronous comparator level |
| gen_hit | input | 1 | Generated hit strobe (self-test mode) |
| gen_tot | input | TOT_W | ToT of the generated hit, in steps |
| rec_valid | output | 1 | One-cycle strobe of a completed hit record |
| rec_tot | output | TOT_W | ToT of the completed hit |
| busy | output | 1 | Comparator window active |
| hits_total | output | CNT_W | Saturating count of all hits |
| hits_busy | output | CNT_W | Saturating count of hits lost while busy |

## Verification
Comparator pulses are applied at an exact multiple of the step length, at one cycle past that multiple, and far beyond the 4-bit range. Together these separate correct flooring from off-by-one sub-step counting, and show that the result saturates. Self-test hits are sent to an idle channel and then repeated inside the window, including on its very last busy cycle. This shows the difference between a window that is ignored and one that is retriggered or stretched, and it pins down the exact edge where busy ends. Further patterns cover zero-ToT hits, `gen_hit` in comparator mode, a clear that coincides with an increment, and long bursts that drive the counters into saturation.

// File: rtl/tot_hit_pkg.sv
package tot_hit_pkg;
   localparam int unsigned TOT_W_DEF = 4;
   localparam int unsigned CNT_W_DEF = 32;

   function automatic int unsigned width_for(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/tot_sat_counter.sv
module tot_sat_counter #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [WIDTH-1:0] count
);
   localparam logic [WIDTH-1:0] MAX_VAL = '1;

   if (WIDTH < 2) begin : g_bad_width
      $error("tot_sat_counter: WIDTH must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        count <= '0;
      else if (clr)                      count <= '0;
      else if (inc && count != MAX_VAL)  count <= count + 1'b1;
   end

   p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (count == MAX_VAL && !clr) |=> (count == MAX_VAL));

   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));
endmodule

// File: rtl/tot_pulse_gen.sv
module tot_pulse_gen
   import tot_hit_pkg::*;
#(
   parameter int unsigned TOT_W       = 4,
   parameter int unsigned TICK_CYCLES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             hit,
   input  logic [TOT_W-1:0] tot,
   output logic             window,
   output logic             lost
);
   localparam int unsigned MAX_LEN = ((1 << TOT_W) - 1) * TICK_CYCLES;
   localparam int unsigned LEN_W   = width_for(MAX_LEN);

   logic [LEN_W-1:0] left_q;
   logic             take;

   assign window = (left_q != '0);
   assign take   = en && hit && !window;
   assign lost   = en && hit && window;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       left_q <= '0;
      else if (take)    left_q <= LEN_W'(tot) * LEN_W'(TICK_CYCLES);
      else if (window)  left_q <= left_q - 1'b1;
   end

   // a hit inside the window never lengthens what is left of it
   p_no_retrigger_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && window) |=> (left_q < $past(left_q)));
endmodule

// File: rtl/tot_measure.sv
module tot_measure
   import tot_hit_pkg::*;
#(
   parameter int unsigned TOT_W       = 4,
   parameter int unsigned TICK_CYCLES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp,
   output logic             rise,
   output logic             rec_valid,
   output logic [TOT_W-1:0] rec_tot
);
   localparam logic [TOT_W-1:0] TOT_MAX = '1;
   localparam int unsigned      SUB_W   = width_for(TICK_CYCLES - 1);

   logic             cmp_d;
   logic             step_done;
   logic [TOT_W-1:0] tot_q;

   if (TICK_CYCLES == 1) begin : g_unit_step
      assign step_done = 1'b1;
   end else begin : g_div_step
      logic [SUB_W-1:0] sub_q;
      assign step_done = (sub_q == SUB_W'(TICK_CYCLES - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  sub_q <= '0;
         else if (!cmp || step_done)  sub_q <= '0;
         else                         sub_q <= sub_q + 1'b1;
      end
   end

   assign rise = cmp && !cmp_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_d     <= 1'b0;
         tot_q     <= '0;
         rec_valid <= 1'b0;
         rec_tot   <= '0;
      end else begin
         cmp_d     <= cmp;
         rec_valid <= cmp_d && !cmp;
         if (cmp_d && !cmp) rec_tot <= tot_q;
         if (!cmp)                                 tot_q <= '0;
         else if (step_done && tot_q != TOT_MAX)   tot_q <= tot_q + 1'b1;
      end
   end

   p_record_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_d && !cmp) |=> rec_valid);

   p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |=> !rec_valid);
endmodule

// File: rtl/tot_hit_channel.sv
module tot_hit_channel
   import tot_hit_pkg::*;
#(
   parameter int unsigned TOT_W       = TOT_W_DEF,
   parameter int unsigned CNT_W       = CNT_W_DEF,
   parameter int unsigned TICK_CYCLES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             selftest_en,
   input  logic             cmp_in,
   input  logic             gen_hit,
   input  logic [TOT_W-1:0] gen_tot,
   output logic             rec_valid,
   output logic [TOT_W-1:0] rec_tot,
   output logic             busy,
   output logic [CNT_W-1:0] hits_total,
   output logic [CNT_W-1:0] hits_busy
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (TICK_CYCLES < 1) begin : g_bad_tick
      $error("tot_hit_channel: TICK_CYCLES must be at least 1");
   end
   if (TOT_W < 1 || TOT_W > 8) begin : g_bad_tot
      $error("tot_hit_channel: TOT_W must be 1..8");
   end

   logic gen_window, gen_lost, cmp_sel, cmp_rise, total_inc;

   tot_pulse_gen #(.TOT_W(TOT_W), .TICK_CYCLES(TICK_CYCLES)) u_gen (
      .clk(clk), .rst_n(rst_n), .en(selftest_en), .hit(gen_hit),
      .tot(gen_tot), .window(gen_window), .lost(gen_lost));

   assign cmp_sel = selftest_en ? gen_window : cmp_in;
   assign busy    = cmp_sel;

   tot_measure #(.TOT_W(TOT_W), .TICK_CYCLES(TICK_CYCLES)) u_meas (
      .clk(clk), .rst_n(rst_n), .cmp(cmp_sel), .rise(cmp_rise),
      .rec_valid(rec_valid), .rec_tot(rec_tot));

   assign total_inc = selftest_en ? gen_hit : cmp_rise;

   tot_sat_counter #(.WIDTH(CNT_W)) u_total (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(total_inc), .count(hits_total));

   tot_sat_counter #(.WIDTH(CNT_W)) u_lost (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(gen_lost), .count(hits_busy));

   p_busy_hit_counted_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (selftest_en && busy && gen_hit && !clr && hits_busy != CNT_MAX)
      |=> (hits_busy == $past(hits_busy) + 1'b1));

   p_gen_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!selftest_en && !clr && !cmp_in) |=> $stable(hits_busy));
endmodule

// File: tb/test_tot_hit_channel.sv
module test_tot_hit_channel;
   localparam int TOT_W = 4;
   localparam int CNT_W = 4;
   localparam int TICK  = 2;

   logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, selftest_en = 1'b0;
   logic cmp_in = 1'b0, gen_hit = 1'b0;
   logic [TOT_W-1:0] gen_tot = '0;
   logic rec_valid, busy;
   logic [TOT_W-1:0] rec_tot;
   logic [CNT_W-1:0] hits_total, hits_busy;
   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tot_hit_channel #(.TOT_W(TOT_W), .CNT_W(CNT_W), .TICK_CYCLES(TICK)) i_tot_hit_channel (
      .clk(clk), .rst_n(rst_n), .clr(clr), .selftest_en(selftest_en),
      .cmp_in(cmp_in), .gen_hit(gen_hit), .gen_tot(gen_tot),
      .rec_valid(rec_valid), .rec_tot(rec_tot), .busy(busy),
      .hits_total(hits_total), .hits_busy(hits_busy));

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_counts();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 rec_valid", rec_valid, 0);
      chk("R1 rec_tot", rec_tot, 0);
      chk("R1 busy", busy, 0);
      chk("R1 hits_total", hits_total, 0);
      chk("R1 hits_busy", hits_busy, 0);
   endtask

   // comparator high for len cycles; returns tot of the record
   task automatic ext_pulse(input int len, input string req, input int exp_tot);
      int pulses = 0;
      @(negedge clk); cmp_in = 1'b1;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (rec_valid) pulses++;
      end
      cmp_in = 1'b0;
      @(negedge clk);
      chk({req, " strobe after drop"}, rec_valid, 1);
      chk({req, " tot"}, rec_tot, exp_tot);
      @(negedge clk);
      chk({req, " strobe width"}, rec_valid, 0);
      chk({req, " no early strobe"}, pulses, 0);
   endtask

   task automatic t_external();
      selftest_en = 1'b0;
      clear_counts();
      ext_pulse(6, "R2 len6", 3);
      ext_pulse(7, "R2 len7 floor", 3);
      chk("R6 rising edges counted", hits_total, 2);
      chk("R6 busy count idle", hits_busy, 0);
   endtask

   task automatic t_tot_sat();
      selftest_en = 1'b0;
      ext_pulse(40, "R3 saturated", 15);
   endtask

   // self-test hit of tot t; extra gen_hit pulses at observation indices x1, x2
   task automatic gen_window(input int t, input int x1, input int x2, input string req);
      int n = t * TICK;
      int busy_len = 0;
      int strobes = 0;
      int strobe_at = -1;
      int tot_seen = -1;
      @(negedge clk); gen_hit = 1'b1; gen_tot = TOT_W'(t);
      for (int i = 0; i < n + 4; i++) begin
         @(negedge clk);
         gen_hit = (i == x1 || i == x2);
         gen_tot = 4'd9;
         if (busy) busy_len++;
         if (rec_valid) begin
            strobes++; strobe_at = i; tot_seen = rec_tot;
         end
      end
      gen_hit = 1'b0;
      chk({req, " busy length"}, busy_len, n);
      chk({req, " one record"}, strobes, 1);
      chk({req, " record cycle"}, strobe_at, n + 1);
      chk({req, " record tot"}, tot_seen, t);
   endtask

   task automatic t_loopback();
      selftest_en = 1'b1;
      clear_counts();
      gen_window(5, -1, -1, "R4");
      chk("R6 accepted hit counted", hits_total, 1);
   endtask

   task automatic t_busy_hits();
      selftest_en = 1'b1;
      clear_counts();
      gen_window(4, 2, 4 * TICK - 1, "R5 no retrigger");
      chk("R5 busy hits", hits_busy, 2);
      chk("R6 all hits counted", hits_total, 3);
   endtask

   task automatic t_zero_tot();
      int seen = 0;
      selftest_en = 1'b1;
      clear_counts();
      @(negedge clk); gen_hit = 1'b1; gen_tot = '0;
      @(negedge clk); gen_hit = 1'b0;
      chk("R7 counted", hits_total, 1);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (busy || rec_valid) seen++;
      end
      chk("R7 no window or record", seen, 0);
      chk("R7 not busy hit", hits_busy, 0);
   endtask

   task automatic t_ext_ignore();
      int seen = 0;
      selftest_en = 1'b0;
      clear_counts();
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); gen_hit = 1'b1; gen_tot = 4'd6;
         @(negedge clk); gen_hit = 1'b0;
         if (busy) seen++;
      end
      repeat (3) @(negedge clk);
      chk("R10 busy stays low", seen, 0);
      chk("R10 total unchanged", hits_total, 0);
      chk("R10 busy count unchanged", hits_busy, 0);
   endtask

   task automatic t_clear();
      int strobes = 0;
      int tot_seen = -1;
      selftest_en = 1'b1;
      clear_counts();
      // clear together with an increment
      @(negedge clk); gen_hit = 1'b1; gen_tot = '0; clr = 1'b1;
      @(negedge clk); gen_hit = 1'b0; clr = 1'b0;
      chk("R9 clear beats increment", hits_total, 0);
      // clear inside an active window
      @(negedge clk); gen_hit = 1'b1; gen_tot = 4'd3;
      for (int i = 0; i < 3 * TICK + 4; i++) begin
         @(negedge clk);
         gen_hit = 1'b0;
         clr = (i == 2);
         if (i == 3) chk("R9 cleared mid window", hits_total, 0);
         if (rec_valid) begin strobes++; tot_seen = rec_tot; end
      end
      clr = 1'b0;
      chk("R9 record survives clear", strobes, 1);
      chk("R9 record tot", tot_seen, 3);
   endtask

   task automatic t_cnt_sat();
      selftest_en = 1'b1;
      clear_counts();
      @(negedge clk); gen_hit = 1'b1; gen_tot = 4'd15;
      repeat (20) @(negedge clk);
      gen_hit = 1'b0;
      @(negedge clk);
      chk("R8 total saturates", hits_total, 15);
      chk("R8 busy saturates", hits_busy, 15);
      repeat (15 * TICK + 4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_external();
      t_tot_sat();
      t_loopback();
      t_busy_hits();
      t_zero_tot();
      t_ext_ignore();
      t_clear();
      t_cnt_sat();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule